// File: doc/BRIEF.md
# Serial DAC Command Controller

This block is the digital control core of a 12-bit voltage-output converter. A host sends 16-bit command words over a three-wire serial port whose frames are delimited by an active-low chip select. Bits are taken on rising serial-clock edges while the select is low. When the select goes high, the block decodes the last sixteen bits it received. Depending on the opcode, it then updates a double-buffered pair of registers (a staging register and an output-code register), enters or leaves shutdown, drives a general-purpose logic output, or picks which serial-clock edge a separate data-out path should use.

Several pins override the serial commands. A clear pin forces both registers to a strapped reset code and wakes the block. A power-down pin forces shutdown but cannot end it. A lockout pin, when low, forbids shutdown altogether. All pins are sampled into the system clock domain, so every effect appears a fixed few cycles after the pin changes. The analog section uses the output code and the shutdown flag; shutdown places the analog output in high impedance.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: A frame word has 16 bits, MSB first. Bits 15:13 carry the opcode, bits 12:1 the 12-bit data field, and bit 0 is a zero pad. DIN is sampled only on SCLK rising edges while cs_ni is low, and the command executes after cs_ni rises.
- R2: Opcode 3'b000 changes no output.
- R3: Opcode 3'b001 writes the data field into the staging register and leaves dac_code_o unchanged.
- R4: Opcode 3'b010 writes the data field into both registers and clears shutdown.
- R5: Opcode 3'b011 copies the staging register into the output-code register and clears shutdown.
- R6: Opcode 3'b101 sets shutdown when pd_allow_i is high and has no effect when it is low.
- R7: Opcode 3'b110 drives upo_o high, and opcode 3'b100 drives it low. upo_o is low after reset.
- R8: Opcode 3'b111 sets dout_rise_o to 1 when data bit 11 is 1 and to 0 when data bits 11:10 are 2'b00. The value 2'b01 leaves it unchanged. It is 0 after reset.
- R9: pd_i high while pd_allow_i is high puts the block into shutdown. pd_i returning low does not end shutdown.
- R10: pd_allow_i low ends and prevents shutdown, which includes waking on its falling edge. While in shutdown, commands are still decoded and register contents are kept.
- R11: clr_ni low loads both registers with the reset code (12'h000 when rst_val_i is 0, 12'h800 when it is 1), clears shutdown and drives upo_o low.
- R12: After rst_ni is released, both registers hold the reset code selected by rst_val_i.
- R13: A frame with more than 16 clocks uses the last 16 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_val_i | input | 1 | Reset-code select: 0 gives zero, 1 gives midscale |
| cs_ni | input | 1 | Serial frame select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| clr_ni | input | 1 | Clear to reset code, active low |
| pd_i | input | 1 | Power-down request, active high |
| pd_allow_i | input | 1 | Shutdown permitted when high, lockout when low |
| dac_code_o | output | 12 | Output-code register |
| shdn_o | output | 1 | Shutdown flag |
| upo_o | output | 1 | User-programmable logic output |
| dout_rise_o | output | 1 | Data-out edge select: 1 rising, 0 falling |

## Verification
A wrong staging register stays hidden until a copy command moves it to dac_code_o, so every staging load is followed by a copy and then a compare. A wrong shutdown state shows on shdn_o three to four clocks after the causing pin edge or select release. The bench therefore samples only after that settling time. Because pin overrides and commands share one next-state path, each priority case is driven alone and then in combination with the others.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 3'b000,
    OP_LD_IN   = 3'b001,
    OP_LD_BOTH = 3'b010,
    OP_UPDATE  = 3'b011,
    OP_UPO_LO  = 3'b100,
    OP_SHDN    = 3'b101,
    OP_UPO_HI  = 3'b110,
    OP_MODE    = 3'b111
  } op_e;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              din_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_o
);
  logic              sclk_d_q, cs_n_d_q;
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cs_n_d_q <= 1'b1;
      sr_q     <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      cs_n_d_q <= cs_n_s_i;
      if (!cs_n_s_i && sclk_s_i && !sclk_d_q) sr_q <= {sr_q[WORD_W-2:0], din_s_i};
    end
  end

  assign word_o  = sr_q;
  assign frame_o = cs_n_s_i && !cs_n_d_q;

  a_r1_shift_only_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> $stable(sr_q));
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int WORD_W = DATA_W + OP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              clr_n_s_i,
  input  logic              pd_s_i,
  input  logic              pdl_s_i,
  input  logic              rstval_s_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              shdn_o,
  output logic              upo_o,
  output logic              rise_o
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  op_e               op;
  logic [DATA_W-1:0] data, rst_code;
  logic [DATA_W-1:0] in_q, dac_q;
  logic              shdn_q, upo_q, rise_q;
  logic [1:0]        pup_cnt_q;
  logic              pup_done;

  assign op       = op_e'(word_i[WORD_W-1 -: OP_W]);
  assign data     = word_i[WORD_W-OP_W-1 -: DATA_W];
  assign rst_code = rstval_s_i ? MID : '0;
  assign pup_done = (pup_cnt_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pup_cnt_q <= '0;
      in_q      <= '0;
      dac_q     <= '0;
      upo_q     <= 1'b0;
      rise_q    <= 1'b0;
    end else begin
      if (!pup_done) pup_cnt_q <= pup_cnt_q + 2'd1;
      if (!pup_done || !clr_n_s_i) begin
        in_q  <= rst_code;
        dac_q <= rst_code;
      end else if (frame_i) begin
        case (op)
          OP_LD_IN:   in_q <= data;
          OP_LD_BOTH: begin in_q <= data; dac_q <= data; end
          OP_UPDATE:  dac_q <= in_q;
          default: ;
        endcase
      end
      if (!clr_n_s_i) upo_q <= 1'b0;
      else if (frame_i && op == OP_UPO_LO) upo_q <= 1'b0;
      else if (frame_i && op == OP_UPO_HI) upo_q <= 1'b1;
      if (frame_i && op == OP_MODE) begin
        if (data[DATA_W-1]) rise_q <= 1'b1;
        else if (!data[DATA_W-2]) rise_q <= 1'b0;
      end
    end
  end

  // Lockout first, then clear, then power-down pin, then commands.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shdn_q <= 1'b0;
    else if (!pdl_s_i || !clr_n_s_i) shdn_q <= 1'b0;
    else if (pd_s_i) shdn_q <= 1'b1;
    else if (frame_i && (op == OP_LD_BOTH || op == OP_UPDATE)) shdn_q <= 1'b0;
    else if (frame_i && op == OP_SHDN) shdn_q <= 1'b1;
  end

  assign dac_o  = dac_q;
  assign shdn_o = shdn_q;
  assign upo_o  = upo_q;
  assign rise_o = rise_q;

  a_r10_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdl_s_i |=> !shdn_q);
  a_r9_pd_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_s_i && pdl_s_i && clr_n_s_i |=> shdn_q);
  a_r11_clear_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_s_i && pup_done |=> dac_q == $past(rst_code) && in_q == $past(rst_code));
  a_r11_clear_upo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_s_i |=> !upo_q && !shdn_q);
  a_r2_dac_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i && clr_n_s_i && pup_done |=> $stable(dac_q));
  a_r10_shdn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_q && pdl_s_i && clr_n_s_i && !frame_i |=> shdn_q);
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_val_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              clr_ni,
  input  logic              pd_i,
  input  logic              pd_allow_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              shdn_o,
  output logic              upo_o,
  output logic              dout_rise_o
);
  localparam int WORD_W = DATA_W + dac_cmd_pkg::OP_W + 1;
  localparam int NPIN   = 7;
  // order: {rstval, pdl, pd, clr_n, din, sclk, cs_n}
  localparam logic [NPIN-1:0] PIN_RST = 7'b0101001;

  logic [NPIN-1:0]   pins_s;
  logic [WORD_W-1:0] word;
  logic              frame;

  dac_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_val_i, pd_allow_i, pd_i, clr_ni, din_i, sclk_i, cs_ni}),
    .q_o   (pins_s)
  );

  dac_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_s_i(pins_s[0]),
    .sclk_s_i(pins_s[1]),
    .din_s_i (pins_s[2]),
    .word_o  (word),
    .frame_o (frame)
  );

  dac_cmd_core #(.DATA_W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame),
    .word_i    (word),
    .clr_n_s_i (pins_s[3]),
    .pd_s_i    (pins_s[4]),
    .pdl_s_i   (pins_s[5]),
    .rstval_s_i(pins_s[6]),
    .dac_o     (dac_code_o),
    .shdn_o    (shdn_o),
    .upo_o     (upo_o),
    .rise_o    (dout_rise_o)
  );
endmodule

// File: tb/dac_cmd_ctrl_tb_top.sv
module dac_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_val = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic clr_n = 1'b1, pd = 1'b0, pdl = 1'b1;
  logic [11:0] dac_code;
  logic shdn, upo, rise;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_val_i(rst_val), .cs_ni(cs_n),
    .sclk_i(sclk), .din_i(din), .clr_ni(clr_n), .pd_i(pd),
    .pd_allow_i(pdl), .dac_code_o(dac_code), .shdn_o(shdn),
    .upo_o(upo), .dout_rise_o(rise)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    chk(req, {11'd0, got}, {11'd0, exp});
  endtask

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [11:0] d);
    return {op, d, 1'b0};
  endfunction

  task automatic clock_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    wait_clk(HALF);
    clock_bits(bits, n);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset;
    rst_val = 1'b1;
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(10);
    chk("R12 midscale after reset", dac_code, 12'h800);
    chk1("R12 shdn after reset", shdn, 1'b0);
    chk1("R7 upo default", upo, 1'b0);
    chk1("R8 edge default", rise, 1'b0);
  endtask

  task automatic t_loads;
    send({16'd0, mk(3'b010, 12'hABC)}, 16);
    chk("R1 R4 load both", dac_code, 12'hABC);
    send({16'd0, mk(3'b000, 12'h123)}, 16);
    chk("R2 nop dac", dac_code, 12'hABC);
    chk1("R2 nop upo", upo, 1'b0);
    send({16'd0, mk(3'b001, 12'h555)}, 16);
    chk("R3 staging only", dac_code, 12'hABC);
    send({16'd0, mk(3'b011, 12'h000)}, 16);
    chk("R5 copy staging", dac_code, 12'h555);
  endtask

  task automatic t_upo_mode;
    send({16'd0, mk(3'b110, 12'h000)}, 16);
    chk1("R7 upo high", upo, 1'b1);
    send({16'd0, mk(3'b100, 12'h000)}, 16);
    chk1("R7 upo low", upo, 1'b0);
    send({16'd0, mk(3'b111, 12'h800)}, 16);
    chk1("R8 rising mode", rise, 1'b1);
    send({16'd0, mk(3'b111, 12'h400)}, 16);
    chk1("R8 code 01 keeps", rise, 1'b1);
    send({16'd0, mk(3'b111, 12'h000)}, 16);
    chk1("R8 falling mode", rise, 1'b0);
  endtask

  task automatic t_sw_shdn;
    send({16'd0, mk(3'b101, 12'h000)}, 16);
    chk1("R6 enter shutdown", shdn, 1'b1);
    chk("R10 code kept", dac_code, 12'h555);
    send({16'd0, mk(3'b001, 12'h111)}, 16);
    chk1("R10 port active stays down", shdn, 1'b1);
    send({16'd0, mk(3'b011, 12'h000)}, 16);
    chk1("R5 update wakes", shdn, 1'b0);
    chk("R10 staged during shutdown", dac_code, 12'h111);
    send({16'd0, mk(3'b101, 12'h000)}, 16);
    send({16'd0, mk(3'b010, 12'h2A5)}, 16);
    chk1("R4 load both wakes", shdn, 1'b0);
    chk("R4 load both value", dac_code, 12'h2A5);
  endtask

  task automatic t_pins;
    pdl = 1'b0;
    wait_clk(6);
    send({16'd0, mk(3'b101, 12'h000)}, 16);
    chk1("R6 locked out command", shdn, 1'b0);
    pd = 1'b1;
    wait_clk(6);
    chk1("R10 locked out pin", shdn, 1'b0);
    pdl = 1'b1;
    wait_clk(6);
    chk1("R9 pd enters", shdn, 1'b1);
    pd = 1'b0;
    wait_clk(6);
    chk1("R9 pd low stays", shdn, 1'b1);
    pdl = 1'b0;
    wait_clk(6);
    chk1("R10 pdl fall wakes", shdn, 1'b0);
    chk("R10 code after wake", dac_code, 12'h2A5);
    pdl = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_clear;
    send({16'd0, mk(3'b110, 12'h000)}, 16);
    send({16'd0, mk(3'b101, 12'h000)}, 16);
    rst_val = 1'b0;
    clr_n = 1'b0;
    wait_clk(6);
    chk("R11 clear to zero", dac_code, 12'h000);
    chk1("R11 clear wakes", shdn, 1'b0);
    chk1("R11 clear upo", upo, 1'b0);
    clr_n = 1'b1;
    rst_val = 1'b1;
    wait_clk(4);
    clr_n = 1'b0;
    wait_clk(6);
    clr_n = 1'b1;
    wait_clk(6);
    chk("R11 clear to midscale", dac_code, 12'h800);
    send({16'd0, mk(3'b001, 12'h000)}, 0);
    send({16'd0, mk(3'b011, 12'h000)}, 16);
    chk("R11 staging also midscale", dac_code, 12'h800);
  endtask

  task automatic t_framing;
    send({12'd0, 4'hF, mk(3'b010, 12'h3C3)}, 20);
    chk("R13 long frame", dac_code, 12'h3C3);
    // clocks with select high must not shift
    clock_bits({16'd0, mk(3'b010, 12'hFFF)}, 16);
    wait_clk(4);
    send(32'd0, 0);
    chk("R1 ignore when deselected", dac_code, 12'h3C3);
  endtask

  initial begin
    t_reset();
    t_loads();
    t_upo_mode();
    t_sw_shdn();
    t_pins();
    t_clear();
    t_framing();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule